// File: doc/BRIEF.md
# Halt and Wake-up Sequencer

This block moves a small processor core into a halt state and brings it back out. A halt request from the core stops the main clock enable and drops the power enables of the ADC, DAC and amplifier. It sets the power-down flag and clears the time-out flag. It also sends a one-cycle clear pulse to the watchdog counter and its prescaler. While the core is halted, three events can wake it: a falling edge on a port pin whose wake enable is set, a newly raised interrupt request, and a watchdog overflow. The active-low reset input performs the full initialisation.

Every wake event starts a settle delay of `SETTLE_CYC` cycles, which is 1024 by default. At the end of the delay the block raises `resume_valid` for one cycle and gives a 2-bit code that tells the core how to continue:
- continue at the next instruction;
- take the interrupt;
- do a warm reset of the program counter and stack pointer only.

An interrupt that was already pending when the halt began cannot wake the core. A wake event that arrives during the delay restarts the delay. The power-down and time-out flags let software find out why the core restarted.

The controller has three states. In RUN the core is clocked. In HALT the core is stopped and the block waits for a wake event. SETTLE is the delay. The named transitions are:
- ENTER: RUN to HALT, on `halt_req`.
- WAKE: HALT to SETTLE, on any wake event.
- REWAKE: SETTLE stays in SETTLE with the delay reloaded, on a further wake event.
- RESUME: SETTLE to RUN, when the delay completes with no new wake event in that cycle.

Top module: `halt_wake_ctl`

## Requirements
- R1: After reset, `core_clk_en`, `adc_en`, `dac_en` and `amp_en` are 1. `pdf_flag`, `to_flag`, `wdt_clr`, `resume_valid` and `resume_code` are 0.
- R2: A `halt_req` sampled in RUN takes effect in the next cycle. `core_clk_en`, `adc_en`, `dac_en` and `amp_en` become 0, `pdf_flag` becomes 1, `to_flag` becomes 0, and `wdt_clr` is 1 for exactly one cycle.
- R3: While halted, a high-to-low change on a `port_in` pin whose `port_wake_en` bit is 1 wakes the core with resume code 2'b01 (next instruction). The input passes two synchroniser flops and an edge stage, so the delay starts two cycles after the pin changes. A falling edge on a pin whose wake enable is 0 does not wake the core.
- R4: While halted, an `irq_req` bit that rises wakes the core. The resume code is 2'b10 (take interrupt) when one of the newly raised bits has its `irq_en` bit set and `stack_full` is 0. Otherwise the code is 2'b01.
- R5: An `irq_req` bit that is already 1 when the halt begins does not wake the core, even if it stays high.
- R6: `wdt_ovf` while halted or settling sets `to_flag` and gives resume code 2'b11 (warm reset).
- R7: `resume_valid` rises exactly `SETTLE_CYC` clock edges after the edge that samples the wake event. `core_clk_en` stays 0 until then. In the cycle after `resume_valid`, `core_clk_en` is 1 again and `resume_valid` is 0.
- R8: A wake event during SETTLE restarts the full delay. The final code is the highest code seen since the halt, with warm reset above take interrupt above next instruction.
- R9: A `clr_wdt` pulse in RUN clears `pdf_flag` and leaves `to_flag` unchanged.
- R10: `resume_code` is 2'b00 whenever `resume_valid` is 0.
- R11: In RUN, `wdt_ovf`, `irq_req` and port edges leave `core_clk_en`, `pdf_flag` and `to_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Active-low reset; causes full initialisation |
| halt_req | input | 1 | Halt request from the core |
| clr_wdt | input | 1 | Clear-watchdog instruction pulse |
| port_in | input | PORT_W | Port pins, idle high |
| port_wake_en | input | PORT_W | Per-pin wake enable |
| irq_req | input | IRQ_W | Interrupt request flags |
| irq_en | input | IRQ_W | Interrupt enables |
| stack_full | input | 1 | Core return stack is full |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| core_clk_en | output | 1 | Main clock enable for the core |
| adc_en | output | 1 | ADC power enable |
| dac_en | output | 1 | DAC power enable |
| amp_en | output | 1 | Amplifier power enable |
| wdt_clr | output | 1 | Clears the watchdog counter and prescaler |
| pdf_flag | output | 1 | Power-down flag |
| to_flag | output | 1 | Time-out flag |
| resume_valid | output | 1 | One-cycle strobe at the end of the delay |
| resume_code | output | 2 | 01 next instruction, 10 take interrupt, 11 warm reset |

## Verification
The hardest case to reach is a second wake event that arrives during SETTLE. It must restart the delay and raise the resume code, and a short random run would seldom produce it. The stimulus builds this case directly: it first wakes the core with an enabled interrupt, waits a few hundred cycles inside the delay, and then pulses the watchdog overflow. The bench then expects the warm-reset code a full delay after that pulse. Random rounds set the pending interrupt mask, the enables, the stack-full state and the wake pin before each halt. This covers both the masking of interrupts that were pending at halt and the rule that chooses between continuing and taking the interrupt.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_SETTLE = 2'd2
    } hw_state_e;

    localparam logic [1:0] RES_NONE = 2'b00;
    localparam logic [1:0] RES_NEXT = 2'b01;
    localparam logic [1:0] RES_INTR = 2'b10;
    localparam logic [1:0] RES_WARM = 2'b11;
endpackage

// File: rtl/hw_port_edge.sv
module hw_port_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] wake_en,
    output logic         fall_hit
);
    logic [W-1:0] sync1_q, sync2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '1;
            sync2_q <= '1;
            prev_q  <= '1;
        end else begin
            sync1_q <= pins;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign fall_hit = |(prev_q & ~sync2_q & wake_en);
endmodule

// File: rtl/hw_settle_timer.sv
module hw_settle_timer #(
    parameter int SETTLE_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= '0;
        else if (run && !done)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/hw_fsm.sv
module hw_fsm
    import halt_wake_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             clr_wdt,
    input  logic [IRQ_W-1:0] irq_req,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             stack_full,
    input  logic             wdt_ovf,
    input  logic             port_hit,
    input  logic             settle_done,
    output logic             settle_load,
    output logic             settle_run,
    output logic             core_clk_en,
    output logic             pwr_en,
    output logic             wdt_clr,
    output logic             pdf_flag,
    output logic             to_flag,
    output logic             resume_valid,
    output logic [1:0]       resume_code
);
    hw_state_e        state_q, state_d;
    logic [IRQ_W-1:0] armed_q;
    logic [1:0]       code_q;
    logic [1:0]       new_code;
    logic             wake, irq_hit, irq_take, halted;

    assign halted   = (state_q != ST_RUN);
    assign irq_hit  = |(irq_req & armed_q);
    assign irq_take = |(irq_req & armed_q & irq_en) && !stack_full;

    always_comb begin
        if (wdt_ovf)
            new_code = RES_WARM;
        else if (irq_hit)
            new_code = irq_take ? RES_INTR : RES_NEXT;
        else if (port_hit)
            new_code = RES_NEXT;
        else
            new_code = RES_NONE;
    end

    assign wake = halted && (new_code != RES_NONE);

    // next state: ENTER, WAKE, REWAKE, RESUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (halt_req) state_d = ST_HALT;
            ST_HALT:   if (wake) state_d = ST_SETTLE;
            ST_SETTLE: if (!wake && settle_done) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q  <= '0;
            code_q   <= RES_NONE;
            pdf_flag <= 1'b0;
            to_flag  <= 1'b0;
            wdt_clr  <= 1'b0;
        end else begin
            wdt_clr <= (state_q == ST_RUN) && halt_req;
            if (state_q == ST_RUN) begin
                if (halt_req) begin
                    armed_q  <= ~irq_req;
                    pdf_flag <= 1'b1;
                    to_flag  <= 1'b0;
                    code_q   <= RES_NONE;
                end else if (clr_wdt) begin
                    pdf_flag <= 1'b0;
                end
            end else begin
                armed_q <= armed_q & ~irq_req;
                if (wdt_ovf) to_flag <= 1'b1;
                if (wake && new_code > code_q) code_q <= new_code;
            end
        end
    end

    always_comb begin
        core_clk_en  = (state_q == ST_RUN);
        pwr_en       = (state_q == ST_RUN);
        settle_load  = wake;
        settle_run   = (state_q == ST_SETTLE);
        resume_valid = (state_q == ST_SETTLE) && settle_done && !wake;
        resume_code  = resume_valid ? code_q : RES_NONE;
    end
endmodule

// File: rtl/halt_wake_ctl.sv
module halt_wake_ctl #(
    parameter int PORT_W     = 8,
    parameter int IRQ_W      = 4,
    parameter int SETTLE_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              clr_wdt,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_wake_en,
    input  logic [IRQ_W-1:0]  irq_req,
    input  logic [IRQ_W-1:0]  irq_en,
    input  logic              stack_full,
    input  logic              wdt_ovf,
    output logic              core_clk_en,
    output logic              adc_en,
    output logic              dac_en,
    output logic              amp_en,
    output logic              wdt_clr,
    output logic              pdf_flag,
    output logic              to_flag,
    output logic              resume_valid,
    output logic [1:0]        resume_code
);
    logic port_hit, settle_done, settle_load, settle_run, pwr_en;

    hw_port_edge #(.W(PORT_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .pins(port_in),
        .wake_en(port_wake_en), .fall_hit(port_hit)
    );

    hw_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(settle_load),
        .run(settle_run), .done(settle_done)
    );

    hw_fsm #(.IRQ_W(IRQ_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .clr_wdt(clr_wdt),
        .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
        .wdt_ovf(wdt_ovf), .port_hit(port_hit), .settle_done(settle_done),
        .settle_load(settle_load), .settle_run(settle_run),
        .core_clk_en(core_clk_en), .pwr_en(pwr_en), .wdt_clr(wdt_clr),
        .pdf_flag(pdf_flag), .to_flag(to_flag),
        .resume_valid(resume_valid), .resume_code(resume_code)
    );

    assign adc_en = pwr_en;
    assign dac_en = pwr_en;
    assign amp_en = pwr_en;
endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_req,
    input logic       wdt_ovf,
    input logic       core_clk_en,
    input logic       adc_en,
    input logic       dac_en,
    input logic       amp_en,
    input logic       wdt_clr,
    input logic       pdf_flag,
    input logic       to_flag,
    input logic       resume_valid,
    input logic [1:0] resume_code
);
    AST_HALT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en && halt_req |=> !core_clk_en && !adc_en && !dac_en && !amp_en); // R2
    AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en && halt_req |=> pdf_flag && !to_flag && wdt_clr); // R2
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr); // R2
    AST_WDT_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en && wdt_ovf |=> to_flag); // R6
    AST_WARM_HAS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid && resume_code == 2'b11 |-> to_flag); // R6
    AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |=> core_clk_en && !resume_valid); // R7
    AST_RESUME_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> !core_clk_en && resume_code != 2'b00); // R7
    AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !resume_valid |-> resume_code == 2'b00); // R10
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en && !halt_req |=> core_clk_en); // R11
endmodule

bind halt_wake_ctl halt_wake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wdt_ovf(wdt_ovf),
    .core_clk_en(core_clk_en), .adc_en(adc_en), .dac_en(dac_en),
    .amp_en(amp_en), .wdt_clr(wdt_clr), .pdf_flag(pdf_flag),
    .to_flag(to_flag), .resume_valid(resume_valid), .resume_code(resume_code)
);

// File: tb/sim_halt_wake_ctl.sv
module sim_halt_wake_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int IW = 4;
    localparam int SC = 1024;

    logic clk = 1'b0, rst_n = 1'b0;
    logic halt_req = 0, clr_wdt = 0, stack_full = 0, wdt_ovf = 0;
    logic [PW-1:0] port_in = '1, port_wake_en = '0;
    logic [IW-1:0] irq_req = '0, irq_en = '0;
    logic core_clk_en, adc_en, dac_en, amp_en, wdt_clr, pdf_flag, to_flag, resume_valid;
    logic [1:0] resume_code;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halt_wake_ctl #(.PORT_W(PW), .IRQ_W(IW), .SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .clr_wdt(clr_wdt),
        .port_in(port_in), .port_wake_en(port_wake_en), .irq_req(irq_req),
        .irq_en(irq_en), .stack_full(stack_full), .wdt_ovf(wdt_ovf),
        .core_clk_en(core_clk_en), .adc_en(adc_en), .dac_en(dac_en),
        .amp_en(amp_en), .wdt_clr(wdt_clr), .pdf_flag(pdf_flag),
        .to_flag(to_flag), .resume_valid(resume_valid), .resume_code(resume_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_irq_code(input logic en_bit, input logic sf);
        return (en_bit && !sf) ? 2 : 1;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_halt();
        @(negedge clk); halt_req = 1;
        @(posedge clk);
        @(negedge clk); halt_req = 0;
        chk("R2 clk_en", int'(core_clk_en), 0);
        chk("R2 analog", int'({adc_en, dac_en, amp_en}), 0);
        chk("R2 pdf/to", int'({pdf_flag, to_flag}), 2);
        chk("R2 wdt_clr", int'(wdt_clr), 1);
        @(negedge clk);
        chk("R2 wdt_clr single", int'(wdt_clr), 0);
    endtask

    // stimulus already driven at the current negedge
    task automatic wait_resume(input int exp_code, input int exp_edges, input string req);
        int edges = 0;
        int early = 0;
        bit seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(posedge clk); edges++;
            @(negedge clk); wdt_ovf = 0;
            if (resume_valid) seen = 1;
            else if (core_clk_en || resume_code != 2'b00) early++;
        end
        chk({req, " R7 latency"}, edges, exp_edges);
        chk({req, " code"}, int'(resume_code), exp_code);
        chk("R10 idle code / R7 clk held", early, 0);
        @(negedge clk);
        chk("R7 clk back", int'({core_clk_en, resume_valid}), 2);
    endtask

    task automatic idle_check(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core_clk_en || resume_valid) bad++;
        end
        chk(req, bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd20250101));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 enables", int'({core_clk_en, adc_en, dac_en, amp_en}), 15);
        chk("R1 flags", int'({pdf_flag, to_flag, wdt_clr, resume_valid, resume_code}), 0);

        // R11: events while running
        port_wake_en = '1; irq_req = 4'b0101; wdt_ovf = 1; port_in = 8'h00;
        @(negedge clk); wdt_ovf = 0;
        repeat (8) @(negedge clk);
        chk("R11 run unaffected", int'({core_clk_en, pdf_flag, to_flag}), 4);
        port_in = '1; irq_req = '0;
        repeat (5) @(negedge clk);

        // R6: watchdog wake, then R9 clear
        do_halt();
        wdt_ovf = 1;
        wait_resume(3, SC, "R6 wdt");
        chk("R6 to set", int'({pdf_flag, to_flag}), 3);
        clr_wdt = 1; @(negedge clk); clr_wdt = 0;
        chk("R9 clr_wdt", int'({pdf_flag, to_flag}), 1);

        // R3: disabled pin ignored, enabled pin wakes
        port_wake_en = 8'h0F;
        do_halt();
        port_in[6] = 0;
        idle_check(40, "R3 disabled pin no wake");
        port_in[2] = 0;
        wait_resume(1, SC + 2, "R3 port");
        port_in = '1; repeat (5) @(negedge clk);

        // R5: pending interrupt ignored, then new one taken
        irq_req = 4'b0010; irq_en = 4'b1010; stack_full = 0;
        do_halt();
        idle_check(40, "R5 pending no wake");
        irq_req[3] = 1;
        wait_resume(2, SC, "R4 irq taken");
        irq_req = '0; @(negedge clk);

        // R4: stack full -> next instruction
        irq_en = 4'b0001; stack_full = 1;
        do_halt();
        irq_req[0] = 1;
        wait_resume(1, SC, "R4 stack full");
        irq_req = '0; stack_full = 0; @(negedge clk);

        // R8: rewake during settle raises code and restarts delay
        irq_en = '1;
        do_halt();
        irq_req[1] = 1;
        idle_check(200, "R8 still settling");
        wdt_ovf = 1;
        wait_resume(3, SC, "R8 rewake");
        irq_req = '0; @(negedge clk);

        // R8: lower code after warm does not demote
        do_halt();
        wdt_ovf = 1; @(negedge clk); wdt_ovf = 0;
        repeat (50) @(negedge clk);
        port_wake_en = 8'h01; port_in[0] = 0;
        wait_resume(3, SC + 2, "R8 keep warm");
        port_in = '1; repeat (5) @(negedge clk);

        // random rounds
        for (int r = 0; r < 30; r++) begin
            int src = $urandom_range(2, 0);
            logic [IW-1:0] pre = IW'($urandom);
            int b = $urandom_range(IW-1, 0);
            int pin = $urandom_range(PW-1, 0);
            irq_en = IW'($urandom);
            stack_full = 1'($urandom);
            port_wake_en = PW'($urandom) | (PW'(1) << pin);
            if (src == 1 && pre == '1) src = 0;
            if (src == 1) while (pre[b]) b = (b + 1) % IW;
            irq_req = pre;
            do_halt();
            if (src == 0) begin
                wdt_ovf = 1;
                wait_resume(3, SC, "R6 rand");
            end else if (src == 1) begin
                irq_req[b] = 1;
                wait_resume(exp_irq_code(irq_en[b], stack_full), SC, "R4 R5 rand");
            end else begin
                port_in[pin] = 0;
                wait_resume(1, SC + 2, "R3 rand");
            end
            irq_req = '0; port_in = '1;
            repeat (5) @(negedge clk);
        end
        summary();
    end
endmodule